// File: doc/BRIEF.md
# Aperture Address Remapping Table

This block remaps device addresses that fall inside a fixed aperture onto physical page frames, one 4 KiB page at a time. It keeps one table entry per aperture page. Each entry holds a valid flag and the frame address that the page is mapped to. A device presents an address on the translation port. One cycle later the block returns either the physical address, made of the frame from the table joined to the unchanged 12-bit page offset, or a fault.

Software never addresses the table directly. It first writes the aperture address of a page into an entry-pointer register. A write to the entry-data register then stores an entry at that page, and a read of the entry-data register returns that page's entry. A control register holds a global enable that gates all translation. Reading the control register back lets software confirm that its earlier register writes have completed.

Top module: `apt_remap`

## Requirements
- R1: A request on `xl_req` is answered in the next cycle with `xl_valid` high. When the request is not a fault, `xl_paddr` is `{1'b0, frame, xl_addr[11:0]}`, so the low 12 address bits pass through unchanged.
- R2: The registers are at these offsets: control at 0x24, entry pointer at 0x28 (all 32 bits read back), entry data at 0x2C. `reg_rdata` carries the read value in the cycle after `reg_rd`.
- R3: An entry has its valid flag in bit 31 and its frame address in bits 30:12. A write to 0x2C stores that entry at index (pointer − base) >> 12. Bits 11:0 of the written value are discarded.
- R4: A read of 0x2C returns the entry that the current pointer selects, with bits 11:0 zero. An entry whose valid flag is clear reads as zero.
- R5: An address is inside the aperture only when base ≤ address ≤ base + pages × 4096 − 1. A translation of an address outside that range faults. While the pointer is outside the range, a data write changes no entry and a data read returns zero.
- R6: Bit 0 of the control register is the enable. While it is 0, every translation faults. Writing 1 enables translation and writing 0 disables it.
- R7: Writing an all-zero entry unmaps the page, and later translations of that page fault.
- R8: After reset all entries are invalid, the enable is 0 and the entry pointer is 0.
- R9: A read of any offset other than 0x24, 0x28 or 0x2C returns zero. A write to such an offset changes no register and no entry.
- R10: A read of the control register returns the enable currently stored, in bit 0, with all other bits zero.
- R11: A translation issued in the same cycle as a table write uses the entry as it was before that write.
- R12: A faulting translation drives `xl_fault` high and `xl_paddr` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW (8) | Register byte offset |
| reg_wdata | input | AW (32) | Register write data |
| reg_rdata | output | AW (32) | Register read data, valid the cycle after reg_rd |
| xl_req | input | 1 | Translation request |
| xl_addr | input | AW (32) | Device address to translate |
| xl_valid | output | 1 | Translation result valid |
| xl_fault | output | 1 | Translation faulted |
| xl_paddr | output | AW (32) | Translated physical address, zero on fault |

## Verification
Every result this block produces is due exactly one clock edge after its stimulus. A translation answers at the edge after `xl_req`. A register read answers at the edge after `reg_rd`. A table or control write is visible to any request issued in the following cycle. The bench drives each stimulus on a falling edge, removes it at the next falling edge and samples the outputs there, half a cycle after the single edge that produces them. The case where a write and a translation share one cycle is driven deliberately, and the old entry is expected in that case.

// File: rtl/apt_pkg.sv
package apt_pkg;
  localparam int PAGE_SHIFT = 12;

  localparam logic [7:0] OFF_CTRL = 8'h24;
  localparam logic [7:0] OFF_PTR  = 8'h28;
  localparam logic [7:0] OFF_DATA = 8'h2C;

  typedef enum logic [1:0] {
    RS_NONE,
    RS_CTRL,
    RS_PTR,
    RS_ENTRY
  } rsel_e;
endpackage

// File: rtl/apt_range.sv
module apt_range
  import apt_pkg::*;
#(
  parameter int             AW    = 32,
  parameter logic [AW-1:0]  BASE  = '0,
  parameter int             PAGES = 64,
  parameter int             IDX_W = 6
) (
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  // exclusive upper bound, one bit wider so it never wraps
  localparam logic [AW:0] LIMIT = {1'b0, BASE} + ((AW+1)'(PAGES) << PAGE_SHIFT);

  assign hit = ({1'b0, addr} >= {1'b0, BASE}) && ({1'b0, addr} < LIMIT);
  assign idx = IDX_W'((addr - BASE) >> PAGE_SHIFT);
endmodule

// File: rtl/apt_table.sv
module apt_table #(
  parameter int DEPTH   = 64,
  parameter int IDX_W   = 6,
  parameter int FRAME_W = 19
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic               wvalid,
  input  logic [FRAME_W-1:0] wframe,
  input  logic [IDX_W-1:0]   a_idx,
  output logic               a_valid,
  output logic [FRAME_W-1:0] a_frame,
  input  logic [IDX_W-1:0]   b_idx,
  output logic               b_valid,
  output logic [FRAME_W-1:0] b_frame
);
  // valid flags live in flops so reset can clear them all at once
  logic [DEPTH-1:0]   vld;
  // frame storage has no reset, so it can map onto block RAM
  logic [FRAME_W-1:0] frames [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (we) vld[widx] <= wvalid;
  end

  // read-first on both read ports
  always_ff @(posedge clk) begin
    if (we) frames[widx] <= wframe;
    a_frame <= frames[a_idx];
    b_frame <= frames[b_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid <= 1'b0;
      b_valid <= 1'b0;
    end else begin
      a_valid <= vld[a_idx];
      b_valid <= vld[b_idx];
    end
  end

  // R7: a write with the valid flag clear leaves the entry invalid
  a_r7_clear_write_invalidates: assert property (@(posedge clk) disable iff (rst)
    we && !wvalid |=> !vld[$past(widx)]);

  // R8: entries come out of reset invalid
  a_r8_reset_invalid: assert property (@(posedge clk)
    $past(rst) |-> (vld == '0));
endmodule

// File: rtl/apt_regs.sv
module apt_regs
  import apt_pkg::*;
#(
  parameter int            AW      = 32,
  parameter int            REG_AW  = 8,
  parameter logic [AW-1:0] BASE    = '0,
  parameter int            PAGES   = 64,
  parameter int            IDX_W   = 6,
  parameter int            FRAME_W = 19
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [AW-1:0]      reg_wdata,
  output logic [AW-1:0]      reg_rdata,
  output logic               xl_en,
  output logic               tbl_we,
  output logic [IDX_W-1:0]   tbl_idx,
  output logic               tbl_wvalid,
  output logic [FRAME_W-1:0] tbl_wframe,
  input  logic               tbl_rvalid,
  input  logic [FRAME_W-1:0] tbl_rframe
);
  logic          en_q;
  logic [AW-1:0] ptr_q;
  logic          ptr_hit;
  rsel_e         sel_q;
  logic          sel_hit_q;
  logic          hit_ctrl, hit_ptr, hit_data;

  assign hit_ctrl = (reg_addr == REG_AW'(OFF_CTRL));
  assign hit_ptr  = (reg_addr == REG_AW'(OFF_PTR));
  assign hit_data = (reg_addr == REG_AW'(OFF_DATA));

  apt_range #(.AW(AW), .BASE(BASE), .PAGES(PAGES), .IDX_W(IDX_W)) u_ptr_range (
    .addr (ptr_q),
    .hit  (ptr_hit),
    .idx  (tbl_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      ptr_q <= '0;
    end else if (reg_wr) begin
      if (hit_ctrl) en_q  <= reg_wdata[0];
      if (hit_ptr)  ptr_q <= reg_wdata;
    end
  end

  assign xl_en      = en_q;
  assign tbl_we     = reg_wr && hit_data && ptr_hit;
  assign tbl_wvalid = reg_wdata[AW-1];
  assign tbl_wframe = reg_wdata[AW-2:PAGE_SHIFT];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= RS_NONE;
      sel_hit_q <= 1'b0;
    end else begin
      sel_hit_q <= ptr_hit;
      if (!reg_rd)       sel_q <= RS_NONE;
      else if (hit_ctrl) sel_q <= RS_CTRL;
      else if (hit_ptr)  sel_q <= RS_PTR;
      else if (hit_data) sel_q <= RS_ENTRY;
      else               sel_q <= RS_NONE;
    end
  end

  always_comb begin
    unique case (sel_q)
      RS_CTRL:  reg_rdata = {{(AW-1){1'b0}}, en_q};
      RS_PTR:   reg_rdata = ptr_q;
      RS_ENTRY: reg_rdata = (sel_hit_q && tbl_rvalid) ?
                            {1'b1, tbl_rframe, {PAGE_SHIFT{1'b0}}} : '0;
      default:  reg_rdata = '0;
    endcase
  end

  // R9: writes to an undefined offset touch no register
  a_r9_undef_write_ignored: assert property (@(posedge clk) disable iff (rst)
    reg_wr && !hit_ctrl && !hit_ptr && !hit_data |=> $stable(en_q) && $stable(ptr_q));

  // R5: an out-of-range pointer never produces a table write
  a_r5_no_write_outside: assert property (@(posedge clk) disable iff (rst)
    !ptr_hit |-> !tbl_we);

  // R8: control and pointer registers leave reset cleared
  a_r8_reset_regs: assert property (@(posedge clk)
    $past(rst) |-> !en_q && (ptr_q == '0));
endmodule

// File: rtl/apt_remap.sv
module apt_remap
  import apt_pkg::*;
#(
  parameter int            AW     = 32,
  parameter int            REG_AW = 8,
  parameter logic [AW-1:0] BASE   = 32'h4000_0000,
  parameter int            PAGES  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  output logic [AW-1:0]     reg_rdata,
  input  logic              xl_req,
  input  logic [AW-1:0]     xl_addr,
  output logic              xl_valid,
  output logic              xl_fault,
  output logic [AW-1:0]     xl_paddr
);
  localparam int IDX_W   = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int FRAME_W = AW - 1 - PAGE_SHIFT;

  logic               en;
  logic               tbl_we, tbl_wvalid;
  logic [IDX_W-1:0]   reg_idx, xl_idx;
  logic [FRAME_W-1:0] tbl_wframe;
  logic               a_valid, b_valid;
  logic [FRAME_W-1:0] a_frame, b_frame;
  logic               xl_hit;

  logic                  req_q;
  logic                  pre_ok_q;
  logic [PAGE_SHIFT-1:0] off_q;
  logic                  ok;

  apt_regs #(
    .AW(AW), .REG_AW(REG_AW), .BASE(BASE), .PAGES(PAGES),
    .IDX_W(IDX_W), .FRAME_W(FRAME_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .xl_en      (en),
    .tbl_we     (tbl_we),
    .tbl_idx    (reg_idx),
    .tbl_wvalid (tbl_wvalid),
    .tbl_wframe (tbl_wframe),
    .tbl_rvalid (a_valid),
    .tbl_rframe (a_frame)
  );

  apt_range #(.AW(AW), .BASE(BASE), .PAGES(PAGES), .IDX_W(IDX_W)) u_xl_range (
    .addr (xl_addr),
    .hit  (xl_hit),
    .idx  (xl_idx)
  );

  apt_table #(.DEPTH(PAGES), .IDX_W(IDX_W), .FRAME_W(FRAME_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .we      (tbl_we),
    .widx    (reg_idx),
    .wvalid  (tbl_wvalid),
    .wframe  (tbl_wframe),
    .a_idx   (reg_idx),
    .a_valid (a_valid),
    .a_frame (a_frame),
    .b_idx   (xl_idx),
    .b_valid (b_valid),
    .b_frame (b_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b0;
      pre_ok_q <= 1'b0;
      off_q    <= '0;
    end else begin
      req_q    <= xl_req;
      pre_ok_q <= en && xl_hit;
      off_q    <= xl_addr[PAGE_SHIFT-1:0];
    end
  end

  assign ok       = req_q && pre_ok_q && b_valid;
  assign xl_valid = req_q;
  assign xl_fault = req_q && !ok;
  assign xl_paddr = ok ? {1'b0, b_frame, off_q} : '0;

  // R1: every request is answered in the next cycle, offset preserved
  a_r1_answer_next: assert property (@(posedge clk) disable iff (rst)
    xl_req |=> xl_valid && (xl_fault || (xl_paddr[PAGE_SHIFT-1:0] == $past(xl_addr[PAGE_SHIFT-1:0]))));

  // R5: addresses outside the aperture fault
  a_r5_outside_faults: assert property (@(posedge clk) disable iff (rst)
    xl_req && !xl_hit |=> xl_fault);

  // R6: disabled translation faults
  a_r6_disabled_faults: assert property (@(posedge clk) disable iff (rst)
    xl_req && !en |=> xl_fault);

  // R12: a fault carries a zero address
  a_r12_fault_zero: assert property (@(posedge clk) disable iff (rst)
    xl_fault |-> (xl_paddr == '0) && xl_valid);
endmodule

// File: tb/tb_apt_remap.sv
`timescale 1ns/100ps
module tb_apt_remap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xl_req = 1'b0;
  logic [31:0] xl_addr = '0;
  logic        xl_valid, xl_fault;
  logic [31:0] xl_paddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  apt_remap dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_req(xl_req), .xl_addr(xl_addr),
    .xl_valid(xl_valid), .xl_fault(xl_fault), .xl_paddr(xl_paddr)
  );

  // {address, expected fault, expected physical address}
  localparam logic [64:0] VEC [8] = '{
    {32'h4000_0123, 1'b0, 32'h1234_5123},
    {32'h4003_FFFF, 1'b0, 32'h7FFF_FFFF},
    {32'h4004_0000, 1'b1, 32'h0000_0000},
    {32'h3FFF_FFFF, 1'b1, 32'h0000_0000},
    {32'h4000_5FFF, 1'b0, 32'h0000_1FFF},
    {32'h4000_7010, 1'b1, 32'h0000_0000},
    {32'h4000_1000, 1'b1, 32'h0000_0000},
    {32'h0000_0000, 1'b1, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic translate(input logic [31:0] a, output logic v, output logic f, output logic [31:0] p);
    @(negedge clk);
    xl_req = 1'b1; xl_addr = a;
    @(negedge clk);
    xl_req = 1'b0;
    v = xl_valid; f = xl_fault; p = xl_paddr;
  endtask

  task automatic map(input logic [31:0] page, input logic [31:0] entry);
    reg_write(8'h28, page);
    reg_write(8'h2C, entry);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d, p;
    logic v, f;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R8: reset state
    reg_read(8'h24, d); check("R8 control after reset", d, 32'h0);
    reg_read(8'h28, d); check("R8 pointer after reset", d, 32'h0);
    reg_write(8'h24, 32'h1);
    reg_write(8'h28, 32'h4000_0000);
    reg_read(8'h2C, d); check("R8 entry invalid after reset", d, 32'h0);
    translate(32'h4000_0000, v, f, p);
    check("R8 unmapped faults", {31'b0, f}, 32'h1);
    reg_write(8'h24, 32'h0);

    // R6: disabled translation faults even for a mapped page
    map(32'h4000_0000, 32'h9234_5ABC);
    translate(32'h4000_0123, v, f, p);
    check("R6 disabled fault", {31'b0, f}, 32'h1);
    check("R12 fault address zero", p, 32'h0);
    // R10: only bit 0 of the control is kept
    reg_write(8'h24, 32'h3);
    reg_read(8'h24, d); check("R10 control readback", d, 32'h1);

    map(32'h4003_F000, 32'hFFFF_F000);
    map(32'h4000_5000, 32'h8000_1000);
    map(32'h4000_7000, 32'h0000_3000);

    // R1 R5 R3: vector table
    for (int i = 0; i < 8; i++) begin
      translate(VEC[i][64:33], v, f, p);
      check("R1 valid next cycle", {31'b0, v}, 32'h1);
      check("R5 fault per vector", {31'b0, f}, {31'b0, VEC[i][32]});
      check("R1 translated address", p, VEC[i][31:0]);
    end

    // R4 R3: entry read back, low bits discarded
    reg_write(8'h28, 32'h4000_0000);
    reg_read(8'h2C, d); check("R4 entry readback", d, 32'h9234_5000);
    reg_write(8'h28, 32'h4000_7000);
    reg_read(8'h2C, d); check("R4 invalid entry reads zero", d, 32'h0);

    // R5: pointer outside aperture must not alias onto page 0
    reg_write(8'h28, 32'h4004_0000);
    reg_read(8'h28, d); check("R2 pointer readback", d, 32'h4004_0000);
    reg_write(8'h2C, 32'h8000_5000);
    reg_read(8'h2C, d); check("R5 outside read zero", d, 32'h0);
    translate(32'h4000_0010, v, f, p);
    check("R5 page 0 untouched", p, 32'h1234_5010);

    // R9: undefined offsets
    reg_write(8'h20, 32'h0);
    reg_write(8'h30, 32'h0);
    reg_read(8'h24, d); check("R9 control unchanged", d, 32'h1);
    reg_read(8'h28, d); check("R9 pointer unchanged", d, 32'h4004_0000);
    reg_read(8'h20, d); check("R9 undefined read zero", d, 32'h0);

    // R7: zero entry unmaps
    map(32'h4000_5000, 32'h0);
    translate(32'h4000_5004, v, f, p);
    check("R7 unmapped faults", {31'b0, f}, 32'h1);

    // R11: write and translate in the same cycle
    reg_write(8'h28, 32'h4003_F000);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h2C; reg_wdata = 32'h0;
    xl_req = 1'b1; xl_addr = 32'h4003_F00C;
    @(negedge clk);
    reg_wr = 1'b0; xl_req = 1'b0;
    check("R11 old entry used", xl_paddr, 32'h7FFF_F00C);
    translate(32'h4003_F00C, v, f, p);
    check("R11 new entry next", {31'b0, f}, 32'h1);

    // R6: writing 0 disables
    reg_write(8'h24, 32'h0);
    translate(32'h4000_0010, v, f, p);
    check("R6 disable faults", {31'b0, f}, 32'h1);
    reg_read(8'h24, d); check("R10 control reads zero", d, 32'h0);

    summary();
  end
endmodule